// File: doc/BRIEF.md
# SD Card SPI-Mode Initialization Sequencer

This block takes a freshly powered SD card from its native bus mode into SPI data mode. It does not move bits on the wire itself: it hands single commands (or single dummy bytes) to a separate SPI command engine through a request/done handshake, reads back the R1 status byte and, for long replies, the trailing 32-bit word, and decides the next step from them. It owns the card's chip select and chooses between a slow initialization clock divider and a fast transfer divider.

A run starts with a one-cycle `start` pulse. The sequencer clocks out wake-up filler with the card deselected, resets the card into SPI mode, probes its interface version, checks supply-voltage support, polls the card's power-up handshake, reads back the capacity bit on newer cards, switches CRC checking off, fixes the block length and finally moves to the fast clock. It ends with a one-cycle `init_done` pulse carrying the detected card type, a high-capacity flag and an error code.

Top module: `sd_spi_init_seq`

## Requirements
- R1: After reset `cs_n` is 1, `sck_fast` is 0, `sck_div` equals the slow divider INIT_DIV (250 by default), `card_type` is 0 (none), and `init_done` and `cmd_req` are 0.
- R2: After `start`, exactly FILL_BYTES (10) dummy requests (`cmd_dummy`=1) are issued with `cs_n`=1 and the slow clock, before any command.
- R3: The reset command (index 0, argument 0) advances only on a reply of exactly 0x01; any other reply is retried after a pause, at most CMD0_TRIES (5) attempts in total; when the last fails, the run ends with `init_err`=1 (no card) and `card_type`=0.
- R4: The interface probe (index 8, argument 0x1AA, long reply) takes the legacy path when R1 bit 2 (illegal command) is set; R1 bit 7 or bit 3 set ends the run with `init_err`=3 and `card_type`=4 (unknown); otherwise the returned word bits 11:0 must equal 0x1AA, else `init_err`=2 (unusable) and `card_type`=4.
- R5: The first operating-conditions read (index 58, long reply) ends the run with `init_err`=3, type 4 when R1 bit 7, 3 or 2 is set, and with `init_err`=2, type 4 when word bit 20 (3.3 V support) is clear.
- R6: Each power-up poll is an application prefix (index 55, argument 0) followed by index 41 whose argument has bit 30 set exactly on the version-2 path; polling repeats while R1 bit 0 is set and the poll timer of OP_TMO_CYC cycles has not expired; a final R1 other than 0x00 gives `init_err`=4 and type 4.
- R7: On the version-2 path a second index-58 read follows; word bit 30 set gives `card_type`=3 with `card_hc`=1, clear gives `card_type`=2; the legacy path gives `card_type`=1 with no second read.
- R8: Then index 59 with argument 0 and index 16 with argument BLOCK_LEN (512) are issued; a non-zero R1 to either ends the run with `init_err`=3, the detected type kept and the slow clock kept.
- R9: On success `sck_fast` becomes 1 and `sck_div` equals `xfer_div` when it is at least MIN_DIV (4 by default, the 25 MHz limit), else MIN_DIV with `init_err`=5 (clamped); otherwise `init_err`=0.
- R10: At most one request is outstanding; `init_done` is a one-cycle pulse with `cs_n`=1; a `start` during a run is ignored, so a run gives one done pulse.
- R11: A new `start` returns the clock to the slow divider until that run succeeds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse that begins one initialization run |
| xfer_div | input | 8 | Requested transfer-clock divider |
| cmd_req | output | 1 | One-cycle request to the command engine |
| cmd_dummy | output | 1 | Request is one 0xFF filler byte, not a command |
| cmd_idx | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_long | output | 1 | Engine must also collect a 32-bit trailing word |
| cmd_done | input | 1 | Engine finished the outstanding request |
| cmd_r1 | input | 8 | R1 status byte (0xFF for no reply) |
| cmd_word | input | 32 | Trailing word of a long reply |
| cs_n | output | 1 | Card chip select, active low |
| sck_fast | output | 1 | Fast divider in use |
| sck_div | output | 8 | Divider for the serial clock generator |
| card_type | output | 3 | 0 none, 1 v1, 2 v2 standard, 3 v2 high capacity, 4 unknown |
| card_hc | output | 1 | High-capacity card detected |
| init_done | output | 1 | One-cycle end-of-run pulse |
| init_err | output | 3 | 0 ok, 1 no card, 2 unusable, 3 command error, 4 not ready, 5 clock clamped |

## Verification
The bench aims at the retry boundary of the reset command (four failures then success, against five failures), where an off-by-one either reports a missing card that answered or keeps retrying past the limit. It corrupts the probe echo, clears the voltage bit and holds the card busy until the poll timer runs out, each of which a careless design would pass as a usable card. It checks that the capacity request bit goes only to version-2 cards and that a divider of 3 is clamped while 4 passes unchanged, and it fires a second `start` mid-run, which a design without the single-run rule would answer with a restarted sequence and two done pulses.

// File: rtl/sdi_pkg.sv
// Shared types and bit positions for the SD SPI-mode initialization sequencer.
package sdi_pkg;

    typedef enum logic [2:0] {
        CT_NONE    = 3'd0,
        CT_V1      = 3'd1,
        CT_V2SC    = 3'd2,
        CT_V2HC    = 3'd3,
        CT_UNKNOWN = 3'd4
    } card_t;

    typedef enum logic [2:0] {
        ER_OK        = 3'd0,
        ER_NO_CARD   = 3'd1,
        ER_UNUSABLE  = 3'd2,
        ER_CMD       = 3'd3,
        ER_NOT_READY = 3'd4,
        ER_CLAMP     = 3'd5
    } err_t;

    typedef enum logic [3:0] {
        S_FILL, S_RESET, S_IFCOND, S_OCR_A, S_APP,
        S_OPCOND, S_OCR_B, S_CRCOFF, S_BLKLEN
    } step_t;

    typedef enum logic [2:0] {
        P_IDLE, P_ISSUE, P_WAIT, P_PAUSE, P_DONE
    } phase_t;

    localparam int R1_IDLE_BIT    = 0;
    localparam int R1_ILLEGAL_BIT = 2;
    localparam int R1_CRCERR_BIT  = 3;
    localparam int R1_NORESP_BIT  = 7;
    localparam int OCR_V33_BIT    = 20;
    localparam int OCR_CAP_BIT    = 30;
    localparam logic [11:0] IFCOND_ECHO = 12'h1AA;

endpackage

// File: rtl/sdi_countdown.sv
// Loadable down-counter; 'expired' is high whenever the count sits at zero.
// Assumes load_val fits in W bits; counts one per clock until zero.
module sdi_countdown #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    // Load on request, otherwise step down toward zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sdi_clk_pick.sv
// Serial-clock divider selection: slow divider during initialization, the
// requested transfer divider (clamped to the fastest legal one) after success.
// Assumes req_div is held steady while a run is in progress.
module sdi_clk_pick #(
    parameter int DIV_W    = 8,
    parameter int INIT_DIV = 250,
    parameter int MIN_DIV  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             revert,
    input  logic             apply,
    input  logic [DIV_W-1:0] req_div,
    output logic             clamped,
    output logic             sck_fast,
    output logic [DIV_W-1:0] sck_div
);
    localparam logic [DIV_W-1:0] SLOW = DIV_W'(INIT_DIV);
    localparam logic [DIV_W-1:0] FLOOR = DIV_W'(MIN_DIV);

    logic [DIV_W-1:0] fast_q;

    assign clamped = (req_div < FLOOR);

    // Latch the (clamped) transfer divider on success; drop back on a new run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_fast <= 1'b0;
            fast_q   <= FLOOR;
        end else if (revert) begin
            sck_fast <= 1'b0;
        end else if (apply) begin
            sck_fast <= 1'b1;
            fast_q   <= clamped ? FLOOR : req_div;
        end
    end

    assign sck_div = sck_fast ? fast_q : SLOW;

    // R9: the fast divider never exceeds the transfer-rate ceiling.
    assert_fast_floor_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sck_fast |-> (sck_div >= FLOOR));
    // R11: a new run drops back to the slow divider.
    assert_revert_slow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        revert |=> !sck_fast);
endmodule

// File: rtl/sdi_seq_ctl.sv
// Step sequencer for SD SPI-mode bring-up. Issues one request at a time to
// the command engine, waits for its done pulse, and decides the next step
// from the R1 byte and trailing word. Assumes cmd_done arrives at least one
// cycle after cmd_req and only for an outstanding request.
module sdi_seq_ctl
    import sdi_pkg::*;
#(
    parameter int FILL_BYTES = 10,
    parameter int CMD0_TRIES = 5,
    parameter int BLOCK_LEN  = 512
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        cmd_done,
    input  logic [7:0]  cmd_r1,
    input  logic [31:0] cmd_word,
    input  logic        pause_exp,
    input  logic        op_exp,
    input  logic        clamped,
    output logic        cmd_req,
    output logic        cmd_dummy,
    output logic [5:0]  cmd_idx,
    output logic [31:0] cmd_arg,
    output logic        cmd_long,
    output logic        cs_n,
    output logic        pause_load,
    output logic        op_load,
    output logic        clk_apply,
    output logic        clk_revert,
    output logic        init_done,
    output card_t       card_type,
    output err_t        init_err
);
    localparam int FILL_W = $clog2(FILL_BYTES + 1);
    localparam int TRY_W  = $clog2(CMD0_TRIES + 1);
    localparam logic [FILL_W-1:0] FILL_LAST = FILL_W'(FILL_BYTES - 1);
    localparam logic [TRY_W-1:0]  TRY_LAST  = TRY_W'(CMD0_TRIES - 1);

    phase_t            phase_q, phase_d;
    step_t             step_q,  step_d;
    logic [FILL_W-1:0] fill_q,  fill_d;
    logic [TRY_W-1:0]  tries_q, tries_d;
    logic              v2_q,    v2_d;
    card_t             type_q,  type_d;
    err_t              err_q,   err_d;

    logic r1_bad;
    assign r1_bad = cmd_r1[R1_NORESP_BIT] | cmd_r1[R1_CRCERR_BIT];

    // Request fields for the current step.
    always_comb begin
        cmd_idx  = 6'd0;
        cmd_arg  = 32'd0;
        cmd_long = 1'b0;
        unique case (step_q)
            S_FILL:   cmd_idx = 6'd0;
            S_RESET:  cmd_idx = 6'd0;
            S_IFCOND: begin cmd_idx = 6'd8;  cmd_arg = {20'd0, IFCOND_ECHO}; cmd_long = 1'b1; end
            S_OCR_A,
            S_OCR_B:  begin cmd_idx = 6'd58; cmd_long = 1'b1; end
            S_APP:    cmd_idx = 6'd55;
            S_OPCOND: begin cmd_idx = 6'd41; cmd_arg[OCR_CAP_BIT] = v2_q; end
            S_CRCOFF: cmd_idx = 6'd59;
            S_BLKLEN: begin cmd_idx = 6'd16; cmd_arg = 32'(BLOCK_LEN); end
            default:  cmd_idx = 6'd0;
        endcase
    end

    assign cmd_req   = (phase_q == P_ISSUE);
    assign cmd_dummy = (step_q == S_FILL);
    assign cs_n      = !((phase_q == P_ISSUE || phase_q == P_WAIT || phase_q == P_PAUSE)
                         && step_q != S_FILL);
    assign init_done = (phase_q == P_DONE);
    assign card_type = type_q;
    assign init_err  = err_q;

    // Next-step decision from the engine's reply.
    always_comb begin
        phase_d = phase_q; step_d = step_q; fill_d = fill_q; tries_d = tries_q;
        v2_d = v2_q; type_d = type_q; err_d = err_q;
        pause_load = 1'b0; op_load = 1'b0; clk_apply = 1'b0; clk_revert = 1'b0;
        unique case (phase_q)
            P_IDLE: if (start) begin
                clk_revert = 1'b1;
                phase_d = P_ISSUE; step_d = S_FILL; fill_d = '0; tries_d = '0;
                v2_d = 1'b0; type_d = CT_NONE; err_d = ER_OK;
            end
            P_ISSUE: phase_d = P_WAIT;
            P_PAUSE: if (pause_exp) phase_d = P_ISSUE;
            P_DONE:  phase_d = P_IDLE;
            P_WAIT: if (cmd_done) begin
                phase_d = P_ISSUE;
                unique case (step_q)
                    S_FILL: begin
                        if (fill_q == FILL_LAST) step_d = S_RESET;
                        else                     fill_d = fill_q + 1'b1;
                    end
                    S_RESET: begin
                        if (cmd_r1 == 8'h01) step_d = S_IFCOND;
                        else if (tries_q == TRY_LAST) begin
                            phase_d = P_DONE; type_d = CT_NONE; err_d = ER_NO_CARD;
                        end else begin
                            tries_d = tries_q + 1'b1; pause_load = 1'b1; phase_d = P_PAUSE;
                        end
                    end
                    S_IFCOND: begin
                        if (r1_bad) begin
                            phase_d = P_DONE; type_d = CT_UNKNOWN; err_d = ER_CMD;
                        end else if (cmd_r1[R1_ILLEGAL_BIT]) begin
                            v2_d = 1'b0; step_d = S_OCR_A;
                        end else if (cmd_word[11:0] != IFCOND_ECHO) begin
                            phase_d = P_DONE; type_d = CT_UNKNOWN; err_d = ER_UNUSABLE;
                        end else begin
                            v2_d = 1'b1; step_d = S_OCR_A;
                        end
                    end
                    S_OCR_A: begin
                        if (r1_bad || cmd_r1[R1_ILLEGAL_BIT]) begin
                            phase_d = P_DONE; type_d = CT_UNKNOWN; err_d = ER_CMD;
                        end else if (!cmd_word[OCR_V33_BIT]) begin
                            phase_d = P_DONE; type_d = CT_UNKNOWN; err_d = ER_UNUSABLE;
                        end else begin
                            op_load = 1'b1; step_d = S_APP;
                        end
                    end
                    S_APP: step_d = S_OPCOND;
                    S_OPCOND: begin
                        if (cmd_r1[R1_IDLE_BIT] && !op_exp) step_d = S_APP;
                        else if (cmd_r1 != 8'h00) begin
                            phase_d = P_DONE; type_d = CT_UNKNOWN; err_d = ER_NOT_READY;
                        end else if (v2_q) step_d = S_OCR_B;
                        else begin
                            type_d = CT_V1; step_d = S_CRCOFF;
                        end
                    end
                    S_OCR_B: begin
                        if (cmd_r1 != 8'h00) begin
                            phase_d = P_DONE; type_d = CT_UNKNOWN; err_d = ER_CMD;
                        end else begin
                            type_d = cmd_word[OCR_CAP_BIT] ? CT_V2HC : CT_V2SC;
                            step_d = S_CRCOFF;
                        end
                    end
                    S_CRCOFF: begin
                        if (cmd_r1 != 8'h00) begin phase_d = P_DONE; err_d = ER_CMD; end
                        else step_d = S_BLKLEN;
                    end
                    S_BLKLEN: begin
                        phase_d = P_DONE;
                        if (cmd_r1 != 8'h00) err_d = ER_CMD;
                        else begin
                            clk_apply = 1'b1;
                            err_d = clamped ? ER_CLAMP : ER_OK;
                        end
                    end
                    default: phase_d = P_IDLE;
                endcase
            end
            default: phase_d = P_IDLE;
        endcase
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= P_IDLE; step_q <= S_FILL; fill_q <= '0; tries_q <= '0;
            v2_q <= 1'b0; type_q <= CT_NONE; err_q <= ER_OK;
        end else begin
            phase_q <= phase_d; step_q <= step_d; fill_q <= fill_d; tries_q <= tries_d;
            v2_q <= v2_d; type_q <= type_d; err_q <= err_d;
        end
    end

    // R10: no new request while one is still outstanding.
    assert_single_outstanding_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == P_WAIT && !cmd_done) |=> !cmd_req);
    // R10: the end-of-run indication lasts one cycle.
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> !init_done);
    // R3: the reset-command retry counter stays within its limit.
    assert_retry_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tries_q <= TRY_LAST);
    // R3: a missing card is never reported with a detected type.
    assert_nocard_type_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && init_err == ER_NO_CARD) |-> card_type == CT_NONE);
endmodule

// File: rtl/sd_spi_init_seq.sv
// Top of the SD SPI-mode initialization sequencer: step controller, retry
// pause timer, power-up poll timer and serial-clock divider selection.
// Assumes a command engine that answers each request with one cmd_done pulse.
module sd_spi_init_seq
    import sdi_pkg::*;
#(
    parameter int SYS_CLK_KHZ  = 100000,
    parameter int INIT_KHZ     = 400,
    parameter int MAX_XFER_KHZ = 25000,
    parameter int DIV_W        = 8,
    parameter int FILL_BYTES   = 10,
    parameter int CMD0_TRIES   = 5,
    parameter int PAUSE_CYC    = 1000,
    parameter int OP_TMO_CYC   = 100000,
    parameter int BLOCK_LEN    = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DIV_W-1:0] xfer_div,
    output logic             cmd_req,
    output logic             cmd_dummy,
    output logic [5:0]       cmd_idx,
    output logic [31:0]      cmd_arg,
    output logic             cmd_long,
    input  logic             cmd_done,
    input  logic [7:0]       cmd_r1,
    input  logic [31:0]      cmd_word,
    output logic             cs_n,
    output logic             sck_fast,
    output logic [DIV_W-1:0] sck_div,
    output logic [2:0]       card_type,
    output logic             card_hc,
    output logic             init_done,
    output logic [2:0]       init_err
);
    localparam int INIT_DIV = (SYS_CLK_KHZ + INIT_KHZ - 1) / INIT_KHZ;
    localparam int MIN_DIV  = (SYS_CLK_KHZ + MAX_XFER_KHZ - 1) / MAX_XFER_KHZ;
    localparam int PAUSE_W  = $clog2(PAUSE_CYC + 1);
    localparam int TMO_W    = $clog2(OP_TMO_CYC + 1);

    logic  pause_load, pause_exp, op_load, op_exp;
    logic  clk_apply, clk_revert, clamped;
    card_t type_w;
    err_t  err_w;

    sdi_seq_ctl #(
        .FILL_BYTES (FILL_BYTES),
        .CMD0_TRIES (CMD0_TRIES),
        .BLOCK_LEN  (BLOCK_LEN)
    ) ctl_i (
        .clk, .rst_n, .start, .cmd_done, .cmd_r1, .cmd_word,
        .pause_exp, .op_exp, .clamped,
        .cmd_req, .cmd_dummy, .cmd_idx, .cmd_arg, .cmd_long, .cs_n,
        .pause_load, .op_load, .clk_apply, .clk_revert,
        .init_done, .card_type(type_w), .init_err(err_w)
    );

    sdi_countdown #(.W(PAUSE_W)) pause_i (
        .clk, .rst_n, .load(pause_load), .load_val(PAUSE_W'(PAUSE_CYC)), .expired(pause_exp)
    );

    sdi_countdown #(.W(TMO_W)) optmo_i (
        .clk, .rst_n, .load(op_load), .load_val(TMO_W'(OP_TMO_CYC)), .expired(op_exp)
    );

    sdi_clk_pick #(
        .DIV_W (DIV_W), .INIT_DIV (INIT_DIV), .MIN_DIV (MIN_DIV)
    ) clk_i (
        .clk, .rst_n, .revert(clk_revert), .apply(clk_apply), .req_div(xfer_div),
        .clamped, .sck_fast, .sck_div
    );

    assign card_type = type_w;
    assign init_err  = err_w;
    assign card_hc   = (type_w == CT_V2HC);

    // R2: filler bytes go out deselected and on the slow clock.
    assert_fill_deselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && cmd_dummy) |-> (cs_n && !sck_fast));
    // R9: a clean finish always leaves the fast clock selected.
    assert_ok_goes_fast_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && (init_err == 3'd0 || init_err == 3'd5)) |-> sck_fast);
    // R10: the card is deselected when a run ends.
    assert_done_deselect_R10: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> cs_n);
endmodule

// File: tb/sd_spi_init_seq_tb_top.sv
module sd_spi_init_seq_tb_top;
    localparam int INIT_DIV = 250;
    localparam int MIN_DIV  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  xfer_div = 8'd8;
    logic        cmd_req, cmd_dummy, cmd_long, cs_n, sck_fast, card_hc, init_done;
    logic [5:0]  cmd_idx;
    logic [31:0] cmd_arg;
    logic        cmd_done = 1'b0;
    logic [7:0]  cmd_r1 = 8'hFF;
    logic [31:0] cmd_word = 32'd0;
    logic [7:0]  sck_div;
    logic [2:0]  card_type, init_err;

    always #5 clk = ~clk;

    sd_spi_init_seq #(.PAUSE_CYC(20), .OP_TMO_CYC(3000)) dut_i (
        .clk, .rst_n, .start, .xfer_div,
        .cmd_req, .cmd_dummy, .cmd_idx, .cmd_arg, .cmd_long,
        .cmd_done, .cmd_r1, .cmd_word,
        .cs_n, .sck_fast, .sck_div, .card_type, .card_hc, .init_done, .init_err
    );

    int errors = 0, checks = 0;
    bit finished = 0;

    // Card scenario
    int c0_bad, c8_mode, op_busy;
    bit ocr_v33, ccs;
    logic [7:0] op_final, c16_r1;
    // Card observations
    int fill_cnt, fill_cs_bad, c0_cnt, ocr_cnt, app_cnt, op_cnt, done_cnt, odd_cnt;
    bit hcs_seen, hcs_bad, c8_arg_bad, c16_arg_bad, c59_arg_bad, c59_seen, c16_seen;
    // Expected results
    int e_err, e_type, e_c0, e_ocr, e_div;
    bit e_fast, e_v2, e_op, e_reach;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Behavioural card plus command engine: answers each request after 1..3 cycles.
    int dly = 0; bit pend = 0;
    always @(negedge clk) begin
        if (cmd_done) cmd_done = 1'b0;
        if (init_done) done_cnt++;
        if (cmd_req) begin
            pend = 1; dly = 1 + int'($urandom % 3); cmd_word = 32'd0;
            if (cmd_dummy) begin
                fill_cnt++; if (!cs_n) fill_cs_bad++; cmd_r1 = 8'hFF;
            end else begin
                case (cmd_idx)
                    6'd0: begin c0_cnt++; cmd_r1 = (c0_cnt <= c0_bad) ? 8'hFF : 8'h01; end
                    6'd8: begin
                        if (cmd_arg != 32'h1AA || !cmd_long) c8_arg_bad = 1;
                        case (c8_mode)
                            0: begin cmd_r1 = 8'h01; cmd_word = 32'h0000_01AA; end
                            1: cmd_r1 = 8'h05;
                            2: begin cmd_r1 = 8'h01; cmd_word = 32'h0000_02AA; end
                            default: cmd_r1 = 8'h09;
                        endcase
                    end
                    6'd58: begin
                        ocr_cnt++;
                        cmd_r1 = (ocr_cnt > 1) ? 8'h00 : 8'h01;
                        cmd_word = 32'h00FF_8000;
                        cmd_word[20] = ocr_v33; cmd_word[30] = ccs;
                    end
                    6'd55: begin app_cnt++; cmd_r1 = 8'h01; end
                    6'd41: begin
                        op_cnt++;
                        if (op_cnt == 1) hcs_seen = cmd_arg[30];
                        else if (cmd_arg[30] != hcs_seen) hcs_bad = 1;
                        cmd_r1 = (op_busy >= 200 || op_cnt <= op_busy) ? 8'h01 : op_final;
                    end
                    6'd59: begin c59_seen = 1; if (cmd_arg != 0) c59_arg_bad = 1; cmd_r1 = 8'h00; end
                    6'd16: begin c16_seen = 1; if (cmd_arg != 512) c16_arg_bad = 1; cmd_r1 = c16_r1; end
                    default: begin odd_cnt++; cmd_r1 = 8'h04; end
                endcase
            end
        end else if (pend) begin
            if (dly <= 1) begin cmd_done = 1'b1; pend = 0; end
            else dly--;
        end
    end

    task automatic compute_expect();
        e_c0 = (c0_bad >= 5) ? 5 : c0_bad + 1;
        e_fast = 0; e_div = INIT_DIV; e_ocr = 0; e_op = 0; e_reach = 0; e_v2 = (c8_mode == 0);
        if (c0_bad >= 5) begin e_type = 0; e_err = 1; end
        else if (c8_mode == 3) begin e_type = 4; e_err = 3; end
        else if (c8_mode == 2) begin e_type = 4; e_err = 2; end
        else begin
            e_ocr = 1;
            if (!ocr_v33) begin e_type = 4; e_err = 2; end
            else begin
                e_op = 1;
                if (op_busy >= 200 || op_final != 8'h00) begin e_type = 4; e_err = 4; end
                else begin
                    e_type = e_v2 ? (ccs ? 3 : 2) : 1;
                    if (e_v2) e_ocr = 2;
                    e_reach = 1;
                    if (c16_r1 != 8'h00) e_err = 3;
                    else begin
                        e_fast = 1;
                        e_div = (xfer_div < MIN_DIV) ? MIN_DIV : int'(xfer_div);
                        e_err = (xfer_div < MIN_DIV) ? 5 : 0;
                    end
                end
            end
        end
    endtask

    task automatic run_case(input string tag, input bit double_start);
        int waited;
        fill_cnt = 0; fill_cs_bad = 0; c0_cnt = 0; ocr_cnt = 0; app_cnt = 0; op_cnt = 0;
        done_cnt = 0; odd_cnt = 0; hcs_seen = 0; hcs_bad = 0; c8_arg_bad = 0;
        c16_arg_bad = 0; c59_arg_bad = 0; c59_seen = 0; c16_seen = 0;
        compute_expect();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        // R11: the new run sits on the slow clock
        check(!sck_fast && sck_div == INIT_DIV, "R11 slow clock at run start", sck_div, INIT_DIV);
        if (double_start) begin
            repeat (4) @(negedge clk);
            start = 1'b1; @(negedge clk); start = 1'b0;
        end
        waited = 0;
        while (!init_done && waited < 20000) begin @(negedge clk); waited++; end
        if (!init_done) begin
            check(0, {"R10 run never finished ", tag}, 0, 1);
            return;
        end
        check(int'(init_err) == e_err, {"R3-R9 error code ", tag}, init_err, e_err);
        check(int'(card_type) == e_type, {"R7 card type ", tag}, card_type, e_type);
        check(card_hc == (e_type == 3), {"R7 hc flag ", tag}, card_hc, e_type == 3);
        check(sck_fast == e_fast && int'(sck_div) == e_div, {"R9 divider ", tag}, sck_div, e_div);
        check(cs_n, {"R10 deselect at done ", tag}, cs_n, 1);
        check(fill_cnt == 10 && fill_cs_bad == 0, {"R2 filler bytes ", tag}, fill_cnt, 10);
        check(c0_cnt == e_c0, {"R3 reset attempts ", tag}, c0_cnt, e_c0);
        check(!c8_arg_bad, {"R4 probe argument ", tag}, c8_arg_bad, 0);
        check(ocr_cnt == e_ocr, {"R5 R7 OCR reads ", tag}, ocr_cnt, e_ocr);
        check(odd_cnt == 0, {"R3 unexpected command ", tag}, odd_cnt, 0);
        if (e_op) begin
            check(op_cnt >= 1 && app_cnt == op_cnt, {"R6 prefix per poll ", tag}, app_cnt, op_cnt);
            check(hcs_seen == e_v2 && !hcs_bad, {"R6 capacity request bit ", tag}, hcs_seen, e_v2);
        end
        check(c59_seen == e_reach && c16_seen == e_reach && !c59_arg_bad && !c16_arg_bad,
              {"R8 crc-off and block length ", tag}, c16_seen, e_reach);
        repeat (30) @(negedge clk);
        check(done_cnt == 1, {"R10 single done pulse ", tag}, done_cnt, 1);
    endtask

    task automatic set_nominal();
        c0_bad = 0; c8_mode = 0; op_busy = 2; ocr_v33 = 1; ccs = 1;
        op_final = 8'h00; c16_r1 = 8'h00; xfer_div = 8'd8;
    endtask

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(cs_n && !sck_fast && sck_div == INIT_DIV && card_type == 0 && !init_done && !cmd_req,
              "R1 reset state", {cs_n, sck_fast, init_done, cmd_req}, 4'b1000);
        rst_n = 1'b1;
        @(negedge clk);

        set_nominal(); run_case("v2hc", 0);
        set_nominal(); ccs = 0; run_case("v2sc", 1);
        set_nominal(); c8_mode = 1; run_case("v1", 0);
        set_nominal(); c0_bad = 4; run_case("cmd0 four fails", 0);
        set_nominal(); c0_bad = 5; run_case("cmd0 five fails", 0);
        set_nominal(); c8_mode = 2; run_case("bad echo", 0);
        set_nominal(); c8_mode = 3; run_case("probe crc err", 0);
        set_nominal(); ocr_v33 = 0; run_case("no 3v3", 0);
        set_nominal(); op_busy = 255; run_case("poll timeout", 0);
        set_nominal(); op_final = 8'h04; run_case("poll bad r1", 0);
        set_nominal(); c16_r1 = 8'h40; run_case("blklen err", 0);
        set_nominal(); xfer_div = 8'd4; run_case("div 4", 0);
        set_nominal(); xfer_div = 8'd3; run_case("div 3 clamp", 0);
        set_nominal(); xfer_div = 8'd0; run_case("div 0 clamp", 1);

        for (int i = 0; i < 30; i++) begin
            int p;
            p = int'($urandom % 10);
            c0_bad  = (p == 0) ? 5 : int'($urandom % 3);
            p = int'($urandom % 10);
            c8_mode = (p < 5) ? 0 : (p < 8) ? 1 : (p == 8) ? 2 : 3;
            ocr_v33 = ($urandom % 8) != 0;
            op_busy = (($urandom % 10) == 0) ? 255 : int'($urandom % 5);
            op_final = (($urandom % 8) == 0) ? 8'h04 : 8'h00;
            ccs = $urandom % 2;
            c16_r1 = (($urandom % 8) == 0) ? 8'h20 : 8'h00;
            xfer_div = 8'($urandom % 16);
            run_case("random", ($urandom % 4) == 0);
        end

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 190000, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule